// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block keeps a fully associative set of address translations for a 32-bit logical address space. Each slot records a virtual page base, its own page-size code (eight sizes from 1 KB to 16 MB), a context tag, a physical page base, read/write/execute permission bits, a zone selector and four storage-attribute bits (write-through, cache-inhibit, coherent and guarded). Because the tag comparison is masked according to each slot's own size, pages of different sizes coexist in the same array and are all compared at once.

A combinational lookup port takes a virtual address, a context, an access type and a supervisor flag. In the same cycle it returns a hit flag, the winning slot index, the translated physical address, the attributes, a protection-fault flag and a multiple-match flag. A 32-bit zone register can override a slot's permissions. Software fills slots through a write port that names the target slot (software picks which slot to replace) and inspects them through a combinational read port. A separate search port reports whether any slot matches an address and context, and which slot that is.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every slot is invalid, so no lookup or search hits, the read port shows valid = 0 for every slot, and the zone register is zero.
- R2: A write with `wr_en` high stores all fields into slot `wr_index` at the clock edge, and from the next cycle the read port shows exactly those fields for that slot.
- R3: A valid slot with size code n (0..7) covers 2^(10+2n) bytes: address bits below bit 10+2n are left out of the comparison, and bits 31 down to 10+2n must equal the same bits of `{tag, 10'b0}`.
- R4: On a hit, `lk_paddr` takes its bits at 10+2n and above from `{ppn, 10'b0}` and its bits below 10+2n from `lk_vaddr`. On a miss it is zero.
- R5: A slot whose context field is zero matches any context. Otherwise the slot matches only when the request context equals its context field.
- R6: A slot with valid = 0 never matches, whatever its other fields hold.
- R7: When several slots match, the lowest-indexed one drives the index, address, attributes and fault outputs, and `lk_multi` is 1. With exactly one match `lk_multi` is 0.
- R8: Access type 00 is read and needs perm bit 0. Type 01 is write and needs perm bit 1. Type 10 is execute and needs perm bit 2. Type 11 is treated as a read. `lk_fault` is 1 only on a hit whose access is not granted, and it is 0 on every miss.
- R9: Zone code 00 faults every user-mode access and applies the slot permissions in supervisor mode. Code 01 applies the slot permissions. Code 10 grants everything in supervisor mode and applies the slot permissions in user mode. Code 11 grants everything.
- R10: The zone code for zone selector z is bits [2z+1:2z] of the zone register. A write with `zone_we` high replaces the whole register at the clock edge.
- R11: The search port uses the same matching rules (R3, R5, R6, R7) as the lookup port. Its outcome does not depend on access type, mode or zone.
- R12: `lk_attr` carries the winning slot's attribute bits on a hit and is zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a slot |
| wr_index | input | 6 | Slot to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_tag | input | 22 | Virtual page base, address bits 31:10 |
| wr_size | input | 3 | Page-size code n (2^(10+2n) bytes) |
| wr_ctx | input | 8 | Context tag, 0 = any |
| wr_ppn | input | 22 | Physical page base, address bits 31:10 |
| wr_perm | input | 3 | {execute, write, read} permission |
| wr_zone | input | 4 | Zone selector |
| wr_attr | input | 4 | {guarded, coherent, inhibit, writethrough} |
| rd_index | input | 6 | Slot to inspect |
| rd_valid | output | 1 | Inspected slot valid bit |
| rd_tag | output | 22 | Inspected slot virtual base |
| rd_size | output | 3 | Inspected slot size code |
| rd_ctx | output | 8 | Inspected slot context |
| rd_ppn | output | 22 | Inspected slot physical base |
| rd_perm | output | 3 | Inspected slot permissions |
| rd_zone | output | 4 | Inspected slot zone selector |
| rd_attr | output | 4 | Inspected slot attributes |
| zone_we | input | 1 | Load the zone register |
| zone_wdata | input | 32 | New zone register value |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_ctx | input | 8 | Lookup context |
| lk_acc | input | 2 | Access type (00 read, 01 write, 10 execute, 11 read) |
| lk_super | input | 1 | Supervisor mode |
| lk_hit | output | 1 | Some slot matches |
| lk_multi | output | 1 | More than one slot matches |
| lk_index | output | 6 | Winning slot |
| lk_paddr | output | 32 | Translated address |
| lk_attr | output | 4 | Winning slot attributes |
| lk_fault | output | 1 | Protection fault |
| sr_vaddr | input | 32 | Search address |
| sr_ctx | input | 8 | Search context |
| sr_hit | output | 1 | Search matched |
| sr_index | output | 6 | Lowest matching slot |

## Verification
The bench builds the block with its default parameters: 64 slots, 8-bit contexts, 4-bit zone selectors and 4 attribute bits. The full slot count puts both ends of the priority chain (slots 0 and 63) within reach. Random fills with all eight size codes make 16 MB pages overlap smaller ones, so multiple matches arise naturally, and a narrow range of context values makes context collisions and wildcard matches common. Directed cases pin down the first byte outside a 1 KB page and a 16 MB page, and every zone code in both modes.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

    localparam int VA_W    = 32;
    localparam int MIN_OFF = 10;
    localparam int TAG_W   = VA_W - MIN_OFF;
    localparam int SIZE_W  = 3;
    localparam int CTX_W   = 8;
    localparam int PERM_W  = 3;
    localparam int ZONE_W  = 4;
    localparam int ATTR_W  = 4;
    localparam int ZREG_W  = 2 * (1 << ZONE_W);

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        ZC_NO_USER = 2'b00,
        ZC_ENTRY   = 2'b01,
        ZC_SUPER   = 2'b10,
        ZC_ALL     = 2'b11
    } zone_code_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [SIZE_W-1:0] size;
        logic [CTX_W-1:0]  ctx;
        logic [TAG_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic [ZONE_W-1:0] zone;
        logic [ATTR_W-1:0] attr;
    } slot_t;

    // Mask of the address bits passed straight through for a size code.
    function automatic logic [VA_W-1:0] page_offset_mask(input logic [SIZE_W-1:0] sz);
        logic [VA_W-1:0] one;
        one = {{(VA_W-1){1'b0}}, 1'b1};
        return (one << (MIN_OFF + 2 * int'(sz))) - one;
    endfunction

endpackage

// File: rtl/tlbv_match_array.sv
module tlbv_match_array
    import tlbv_pkg::*;
#(
    parameter int NUM_SLOTS = 64
) (
    input  slot_t [NUM_SLOTS-1:0]  slots_i,
    input  logic  [VA_W-1:0]       vaddr_i,
    input  logic  [CTX_W-1:0]      ctx_i,
    output logic  [NUM_SLOTS-1:0]  match_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [VA_W-1:0] off_mask;
        logic [VA_W-1:0] base;
        logic            page_eq;
        logic            ctx_ok;

        always_comb begin
            off_mask = page_offset_mask(slots_i[g].size);
            base     = {slots_i[g].tag, {MIN_OFF{1'b0}}};
            page_eq  = ((vaddr_i ^ base) & ~off_mask) == '0;
            ctx_ok   = (slots_i[g].ctx == '0) || (slots_i[g].ctx == ctx_i);
            match_o[g] = slots_i[g].valid & page_eq & ctx_ok;
        end
    end

endmodule

// File: rtl/tlbv_prio_pick.sv
module tlbv_prio_pick #(
    parameter int NUM_SLOTS = 64,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] vec_i,
    output logic                 any_o,
    output logic                 multi_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o   = |vec_i;
        multi_o = |(vec_i & (vec_i - NUM_SLOTS'(1)));
    end

    // R7: the reported slot is a matching one and nothing below it matches
    always_comb begin
        if (any_o) begin
            a_r7_pick_is_set: assert (vec_i[idx_o]);
            a_r7_pick_is_lowest: assert ((vec_i & ((NUM_SLOTS'(1) << idx_o) - NUM_SLOTS'(1))) == '0);
        end
    end

endmodule

// File: rtl/tlbv_zone_perm.sv
module tlbv_zone_perm
    import tlbv_pkg::*;
(
    input  logic [PERM_W-1:0] perm_i,
    input  logic [1:0]        zone_code_i,
    input  logic [1:0]        acc_i,
    input  logic              super_i,
    output logic              allowed_o
);

    logic entry_ok;

    always_comb begin
        unique case (acc_e'(acc_i))
            ACC_WRITE: entry_ok = perm_i[1];
            ACC_EXEC:  entry_ok = perm_i[2];
            default:   entry_ok = perm_i[0];
        endcase

        unique case (zone_code_e'(zone_code_i))
            ZC_NO_USER: allowed_o = super_i & entry_ok;
            ZC_ENTRY:   allowed_o = entry_ok;
            ZC_SUPER:   allowed_o = super_i | entry_ok;
            default:    allowed_o = 1'b1;
        endcase
    end

    // R9: code 11 always grants, and user mode under code 00 never does
    always_comb begin
        if (zone_code_i == 2'b11) begin
            a_r9_full_grant: assert (allowed_o);
        end
        if (zone_code_i == 2'b00 && !super_i) begin
            a_r9_user_denied: assert (!allowed_o);
        end
    end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import tlbv_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic              wr_valid,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [TAG_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [ZONE_W-1:0] wr_zone,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_index,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [SIZE_W-1:0] rd_size,
    output logic [CTX_W-1:0]  rd_ctx,
    output logic [TAG_W-1:0]  rd_ppn,
    output logic [PERM_W-1:0] rd_perm,
    output logic [ZONE_W-1:0] rd_zone,
    output logic [ATTR_W-1:0] rd_attr,
    input  logic              zone_we,
    input  logic [ZREG_W-1:0] zone_wdata,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic [1:0]        lk_acc,
    input  logic              lk_super,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [IDX_W-1:0]  lk_index,
    output logic [VA_W-1:0]   lk_paddr,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              lk_fault,
    input  logic [VA_W-1:0]   sr_vaddr,
    input  logic [CTX_W-1:0]  sr_ctx,
    output logic              sr_hit,
    output logic [IDX_W-1:0]  sr_index
);

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
        logic  [ZREG_W-1:0]    zreg;
    } state_t;

    state_t st_d, st_q;

    // ---------------- next-state ----------------
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.slot[wr_index] = '{
                valid: wr_valid,
                tag:   wr_tag,
                size:  wr_size,
                ctx:   wr_ctx,
                ppn:   wr_ppn,
                perm:  wr_perm,
                zone:  wr_zone,
                attr:  wr_attr
            };
        end
        if (zone_we) begin
            st_d.zreg = zone_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- inspection port ----------------
    slot_t rd_slot;

    always_comb begin
        rd_slot  = st_q.slot[rd_index];
        rd_valid = rd_slot.valid;
        rd_tag   = rd_slot.tag;
        rd_size  = rd_slot.size;
        rd_ctx   = rd_slot.ctx;
        rd_ppn   = rd_slot.ppn;
        rd_perm  = rd_slot.perm;
        rd_zone  = rd_slot.zone;
        rd_attr  = rd_slot.attr;
    end

    // ---------------- lookup port ----------------
    logic [NUM_SLOTS-1:0] lk_match;
    logic                 lk_any;
    logic                 lk_many;
    logic [IDX_W-1:0]     lk_pick;

    tlbv_match_array #(.NUM_SLOTS(NUM_SLOTS)) i_lk_match (
        .slots_i (st_q.slot),
        .vaddr_i (lk_vaddr),
        .ctx_i   (lk_ctx),
        .match_o (lk_match)
    );

    tlbv_prio_pick #(.NUM_SLOTS(NUM_SLOTS)) i_lk_pick (
        .vec_i   (lk_match),
        .any_o   (lk_any),
        .multi_o (lk_many),
        .idx_o   (lk_pick)
    );

    slot_t           lk_slot;
    logic [VA_W-1:0] lk_mask;
    logic [1:0]      lk_zcode;
    logic            lk_allowed;

    always_comb begin
        lk_slot  = st_q.slot[lk_pick];
        lk_mask  = page_offset_mask(lk_slot.size);
        lk_zcode = st_q.zreg[{lk_slot.zone, 1'b0} +: 2];
    end

    tlbv_zone_perm i_lk_perm (
        .perm_i      (lk_slot.perm),
        .zone_code_i (lk_zcode),
        .acc_i       (lk_acc),
        .super_i     (lk_super),
        .allowed_o   (lk_allowed)
    );

    always_comb begin
        lk_hit   = lk_any;
        lk_multi = lk_many;
        lk_index = lk_pick;
        lk_paddr = '0;
        lk_attr  = '0;
        lk_fault = 1'b0;
        if (lk_any) begin
            lk_paddr = ({lk_slot.ppn, {MIN_OFF{1'b0}}} & ~lk_mask) | (lk_vaddr & lk_mask);
            lk_attr  = lk_slot.attr;
            lk_fault = ~lk_allowed;
        end
    end

    // ---------------- search port ----------------
    logic [NUM_SLOTS-1:0] sr_match;
    logic                 sr_many;

    tlbv_match_array #(.NUM_SLOTS(NUM_SLOTS)) i_sr_match (
        .slots_i (st_q.slot),
        .vaddr_i (sr_vaddr),
        .ctx_i   (sr_ctx),
        .match_o (sr_match)
    );

    tlbv_prio_pick #(.NUM_SLOTS(NUM_SLOTS)) i_sr_pick (
        .vec_i   (sr_match),
        .any_o   (sr_hit),
        .multi_o (sr_many),
        .idx_o   (sr_index)
    );

    // ---------------- assertions ----------------
    // R7: a multiple match is always also a hit
    a_r7_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit);

    // R8: misses never report a protection fault
    a_r8_miss_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> !lk_fault);

    // R6: the winning slot of a hit is valid
    a_r6_hit_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> st_q.slot[lk_index].valid);

    // R9: zone code 11 never faults
    a_r9_zone_all_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_zcode == 2'b11) |-> !lk_fault);

    // R11: search and lookup agree on identical requests
    a_r11_search_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_vaddr == lk_vaddr && sr_ctx == lk_ctx) |->
            (sr_hit == lk_hit && sr_many == lk_multi && (!sr_hit || sr_index == lk_index)));

    // R2: a write lands in the addressed slot at the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.slot[$past(wr_index)].tag == $past(wr_tag)
                   && st_q.slot[$past(wr_index)].valid == $past(wr_valid)
                   && st_q.slot[$past(wr_index)].ppn == $past(wr_ppn)));

    // R10: the zone register takes the written value
    a_r10_zone_load: assert property (@(posedge clk) disable iff (!rst_n)
        zone_we |=> st_q.zreg == $past(zone_wdata));

endmodule

// File: tb/test_vpage_tlb.sv
module test_vpage_tlb;
    import tlbv_pkg::*;

    localparam int N  = 64;
    localparam int IW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IW-1:0]     wr_index = '0;
    logic              wr_valid = 1'b0;
    logic [TAG_W-1:0]  wr_tag = '0;
    logic [SIZE_W-1:0] wr_size = '0;
    logic [CTX_W-1:0]  wr_ctx = '0;
    logic [TAG_W-1:0]  wr_ppn = '0;
    logic [PERM_W-1:0] wr_perm = '0;
    logic [ZONE_W-1:0] wr_zone = '0;
    logic [ATTR_W-1:0] wr_attr = '0;
    logic [IW-1:0]     rd_index = '0;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [SIZE_W-1:0] rd_size;
    logic [CTX_W-1:0]  rd_ctx;
    logic [TAG_W-1:0]  rd_ppn;
    logic [PERM_W-1:0] rd_perm;
    logic [ZONE_W-1:0] rd_zone;
    logic [ATTR_W-1:0] rd_attr;
    logic              zone_we = 1'b0;
    logic [ZREG_W-1:0] zone_wdata = '0;
    logic [VA_W-1:0]   lk_vaddr = '0;
    logic [CTX_W-1:0]  lk_ctx = '0;
    logic [1:0]        lk_acc = '0;
    logic              lk_super = 1'b0;
    logic              lk_hit, lk_multi, lk_fault;
    logic [IW-1:0]     lk_index;
    logic [VA_W-1:0]   lk_paddr;
    logic [ATTR_W-1:0] lk_attr;
    logic [VA_W-1:0]   sr_vaddr = '0;
    logic [CTX_W-1:0]  sr_ctx = '0;
    logic              sr_hit;
    logic [IW-1:0]     sr_index;

    vpage_tlb #(.NUM_SLOTS(N)) i_vpage_tlb (.*);

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model of the slots
    logic        m_valid [N];
    logic [21:0] m_tag   [N];
    logic [2:0]  m_size  [N];
    logic [7:0]  m_ctx   [N];
    logic [21:0] m_ppn   [N];
    logic [2:0]  m_perm  [N];
    logic [3:0]  m_zone  [N];
    logic [3:0]  m_attr  [N];
    logic [31:0] m_zreg;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] low_mask(input logic [2:0] sz);
        return (32'd1 << (10 + 2 * int'(sz))) - 32'd1;
    endfunction

    function automatic bit slot_matches(input int i, input logic [31:0] va, input logic [7:0] cx);
        logic [31:0] m;
        m = low_mask(m_size[i]);
        return m_valid[i] && ((va & ~m) == ({m_tag[i], 10'b0} & ~m))
               && (m_ctx[i] == 8'd0 || m_ctx[i] == cx);
    endfunction

    task automatic write_slot(input int idx, input logic v, input logic [21:0] tg, input logic [2:0] sz,
                              input logic [7:0] cx, input logic [21:0] pp, input logic [2:0] pm,
                              input logic [3:0] zn, input logic [3:0] at);
        @(negedge clk);
        wr_en = 1'b1; wr_index = IW'(idx); wr_valid = v; wr_tag = tg; wr_size = sz;
        wr_ctx = cx; wr_ppn = pp; wr_perm = pm; wr_zone = zn; wr_attr = at;
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[idx] = v; m_tag[idx] = tg; m_size[idx] = sz; m_ctx[idx] = cx;
        m_ppn[idx] = pp; m_perm[idx] = pm; m_zone[idx] = zn; m_attr[idx] = at;
    endtask

    task automatic write_zone(input logic [31:0] z);
        @(negedge clk);
        zone_we = 1'b1; zone_wdata = z;
        @(negedge clk);
        zone_we = 1'b0;
        m_zreg = z;
    endtask

    task automatic check_read(input int idx);
        rd_index = IW'(idx);
        #1;
        check("R2 valid", 32'(rd_valid), 32'(m_valid[idx]));
        check("R2 tag",   32'(rd_tag),   32'(m_tag[idx]));
        check("R2 size",  32'(rd_size),  32'(m_size[idx]));
        check("R2 ctx",   32'(rd_ctx),   32'(m_ctx[idx]));
        check("R2 ppn",   32'(rd_ppn),   32'(m_ppn[idx]));
        check("R2 perm",  32'(rd_perm),  32'(m_perm[idx]));
        check("R2 zone",  32'(rd_zone),  32'(m_zone[idx]));
        check("R2 attr",  32'(rd_attr),  32'(m_attr[idx]));
    endtask

    // Applies a lookup and a matching search, then compares every output.
    task automatic probe(input logic [31:0] va, input logic [7:0] cx, input logic [1:0] acc, input logic sup);
        int          win;
        int          cnt;
        logic [31:0] m;
        logic [31:0] e_pa;
        logic [3:0]  e_at;
        logic        e_f;
        logic        need;
        logic [1:0]  zc;
        logic        ok;
        @(negedge clk);
        lk_vaddr = va; lk_ctx = cx; lk_acc = acc; lk_super = sup;
        sr_vaddr = va; sr_ctx = cx;
        #1;
        win = -1; cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (slot_matches(i, va, cx)) begin
                if (win < 0) win = i;
                cnt++;
            end
        end
        e_pa = '0; e_at = '0; e_f = 1'b0;
        if (win >= 0) begin
            m    = low_mask(m_size[win]);
            e_pa = ({m_ppn[win], 10'b0} & ~m) | (va & m);
            e_at = m_attr[win];
            need = (acc == 2'b01) ? m_perm[win][1] : (acc == 2'b10) ? m_perm[win][2] : m_perm[win][0];
            zc   = 2'((m_zreg >> (2 * int'(m_zone[win]))) & 32'd3);
            case (zc)
                2'b00:   ok = sup && need;
                2'b01:   ok = need;
                2'b10:   ok = sup || need;
                default: ok = 1'b1;
            endcase
            e_f = !ok;
        end
        check("R3 hit",    32'(lk_hit),   32'(win >= 0));
        check("R7 multi",  32'(lk_multi), 32'(cnt > 1));
        if (win >= 0) check("R7 index", 32'(lk_index), 32'(win));
        check("R4 paddr",  lk_paddr, e_pa);
        check("R12 attr",  32'(lk_attr), 32'(e_at));
        check("R8 fault",  32'(lk_fault), 32'(e_f));
        check("R11 search hit", 32'(sr_hit), 32'(win >= 0));
        if (win >= 0) check("R11 search index", 32'(sr_index), 32'(win));
    endtask

    function automatic logic [31:0] addr_in_slot(input int i);
        logic [31:0] m;
        m = low_mask(m_size[i]);
        return ({m_tag[i], 10'b0} & ~m) | ($urandom & m);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_tag[i] = 0; m_size[i] = 0; m_ctx[i] = 0;
            m_ppn[i] = 0; m_perm[i] = 0; m_zone[i] = 0; m_attr[i] = 0;
        end
        m_zreg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        check_read(0);
        check_read(63);
        probe(32'h0000_0000, 8'd0, 2'b00, 1'b0);
        probe(32'hDEAD_BEEF, 8'd7, 2'b01, 1'b1);

        // R3/R4/R5: 1 KB page in the top slot, context 5, zone 0 with code 01
        write_zone(32'h0000_0001);
        write_slot(63, 1'b1, 22'h0ABCDE, 3'd0, 8'd5, 22'h123456, 3'b111, 4'd0, 4'hA);
        check_read(63);
        probe({22'h0ABCDE, 10'h3FF}, 8'd5, 2'b00, 1'b0);              // R3 last byte hits
        probe({22'h0ABCDE, 10'h000} + 32'h400, 8'd5, 2'b00, 1'b0);    // R3 next page misses
        probe({22'h0ABCDE, 10'h155}, 8'd6, 2'b00, 1'b0);              // R5 other context misses
        // R5: wildcard context
        write_slot(10, 1'b1, 22'h001000, 3'd1, 8'd0, 22'h3FFFF0, 3'b001, 4'd0, 4'h3);
        probe({22'h001000, 10'h2A5}, 8'd200, 2'b00, 1'b0);

        // R3/R4: 16 MB page
        write_slot(20, 1'b1, {8'h12, 14'h0}, 3'd7, 8'd0, {8'hC3, 14'h0}, 3'b011, 4'd0, 4'h5);
        probe(32'h12FF_FFFF, 8'd9, 2'b01, 1'b0);
        probe(32'h1300_0000, 8'd9, 2'b01, 1'b0);
        probe(32'h1234_5678, 8'd1, 2'b10, 1'b0);                      // R8 execute denied

        // R7: two overlapping slots, lowest wins; R6: invalidated slot drops out
        write_slot(3,  1'b1, {8'h40, 14'h0}, 3'd6, 8'd0, {8'h80, 14'h0}, 3'b001, 4'd0, 4'h1);
        write_slot(40, 1'b1, {8'h40, 14'h0}, 3'd7, 8'd0, {8'h90, 14'h0}, 3'b001, 4'd0, 4'h2);
        probe(32'h4001_2345, 8'd0, 2'b00, 1'b0);
        write_slot(3,  1'b0, {8'h40, 14'h0}, 3'd6, 8'd0, {8'h80, 14'h0}, 3'b001, 4'd0, 4'h1);
        probe(32'h4001_2345, 8'd0, 2'b00, 1'b0);

        // R9/R10: read-only slot in zone 9, every zone code, both modes, write access
        write_slot(30, 1'b1, 22'h2AAAAA, 3'd2, 8'd0, 22'h155555, 3'b001, 4'd9, 4'h0);
        for (int zc = 0; zc < 4; zc++) begin
            write_zone(32'(zc) << 18);
            probe(addr_in_slot(30), 8'd0, 2'b01, 1'b0);
            probe(addr_in_slot(30), 8'd0, 2'b01, 1'b1);
            probe(addr_in_slot(30), 8'd0, 2'b00, 1'b0);
        end

        // Random phase: refill the whole array, then mix hits and misses
        for (int i = 0; i < N; i++) begin
            write_slot(i, ($urandom % 10) != 0, 22'($urandom), 3'($urandom), 
                       (($urandom % 4) == 0) ? 8'd0 : 8'(1 + $urandom % 3),
                       22'($urandom), 3'($urandom), 4'($urandom), 4'($urandom));
        end
        write_zone($urandom);
        for (int k = 0; k < 3000; k++) begin
            int          t;
            logic [31:0] va;
            logic [7:0]  cx;
            t  = int'($urandom % N);
            va = (($urandom % 4) != 0) ? addr_in_slot(t) : $urandom;
            cx = (($urandom % 5) != 0) ? m_ctx[t] : 8'($urandom % 4);
            probe(va, cx, 2'($urandom), 1'($urandom));
            if ((k % 200) == 199) begin
                write_zone($urandom);
                write_slot(int'($urandom % N), 1'b1, 22'($urandom), 3'($urandom), 8'($urandom % 4),
                           22'($urandom), 3'($urandom), 4'($urandom), 4'($urandom));
                check_read(int'($urandom % N));
            end
        end
        finish_run();
    end

endmodule